// File: doc/BRIEF.md
# Correctable ECC Error Logger

This block sits beside a bus interface's error-correcting receive path. Each cycle it may see a strobe saying a single-bit data error was detected and corrected. Along with the strobe come the transaction class, the bus role (initiator or target), the two address halves and the attribute bits. The block decides whether that error is one the interface must report. If so, it records the transaction in a small set of log registers and may raise a sticky, maskable status bit that drives an interrupt line.

Reporting happens only when the interface runs in its enhanced operating mode with single-bit correction switched on. Errors seen while acting as initiator are dropped. Errors on target read requests are dropped as well. Errors on the other target receive paths are logged: writes, read completions, configuration writes and split completion messages. The block only observes the transaction, so the transaction itself always completes and is forwarded as if nothing had happened. Software reads the log through a small register port and acknowledges by writing ones to clear.

Top module: `ecc_err_logger`

## Requirements
- R1: An error strobe has no effect on any log register or the status bit unless `mode_enh` and `corr_en` are both 1.
- R2: With `is_target` = 0, an error strobe has no effect on any log register or the status bit, whatever the kind code.
- R3: With `is_target` = 1, kind codes 0 (read request, immediate or split), 4 (configuration write completion message), 6 and 7 have no effect on any log register or the status bit.
- R4: With `is_target` = 1 and kind code 1 (write), 2 (read completion), 3 (configuration write) or 5 (split completion message), the error is logged one cycle after the strobe. Register 1 then holds `addr_lo` and register 2 holds `addr_hi`. Register 3 holds `attr`, zero-extended. In register 0, bit 1 (valid) is set, bits 6:4 hold the kind and bit 7 holds the role.
- R5: Each later logged error overwrites all log fields with the newer transaction.
- R6: A logged error sets status (register 0 bit 0) when `irq_mask` is 0. When `irq_mask` is 1, status keeps its value while the log fields are still updated.
- R7: `irq` always equals the status bit. `err_status` also equals the status bit, and status is 0 after reset.
- R8: A write to register 0 clears status when data bit 0 is 1 and clears valid when data bit 1 is 1. Zero bits and writes to registers 1 to 3 change nothing.
- R9: When a status set and a clear of status occur in the same cycle, status ends up 1. The same holds for valid.
- R10: `reg_rdata` shows the register selected by `reg_addr` without delay. After reset all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe | input | 1 | Correctable error detected this cycle |
| txn_kind | input | 3 | Transaction class code |
| is_target | input | 1 | 1 = block acts as target, 0 = initiator |
| addr_lo | input | ADDR_W | Low address half of the transaction |
| addr_hi | input | ADDR_W | High address half of the transaction |
| attr | input | ATTR_W | Transaction attribute bits |
| mode_enh | input | 1 | Enhanced operating mode active |
| corr_en | input | 1 | Single-bit correction enabled |
| irq_mask | input | 1 | 1 masks setting of the status bit |
| reg_wr | input | 1 | Register write strobe (write-1-to-clear) |
| reg_addr | input | 2 | Register select: 0 ctrl/status, 1 first addr, 2 second addr, 3 attribute |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of selected register |
| err_status | output | 1 | Sticky detected-correctable-error bit |
| irq | output | 1 | Interrupt request |

## Verification
A bad classification shows up one cycle after the strobe. Either a dropped class alters the address registers and the valid bit, or a reportable class leaves them stale. A stuck or wrongly masked status bit appears on `irq` and on register 0 in that same next cycle. A clear that is lost or races a set is visible at the following read of register 0. Every observable therefore sits at most one clock edge from its cause, so each stimulus is compared right after the edge that consumes it.

// File: rtl/ecc_log_pkg.sv
// Shared codes for the correctable error logger.
// Assumes a 3-bit transaction class and a 2-bit register index.
package ecc_log_pkg;

    typedef enum logic [2:0] {
        KIND_RD_REQ   = 3'd0,
        KIND_WR_REQ   = 3'd1,
        KIND_RD_CPL   = 3'd2,
        KIND_CFG_WR   = 3'd3,
        KIND_CFG_CMSG = 3'd4,
        KIND_SPL_CMSG = 3'd5
    } txn_kind_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_ADR1 = 2'd1,
        REG_ADR2 = 2'd2,
        REG_ATTR = 2'd3
    } reg_sel_e;

    localparam int CTRL_STS_BIT  = 0;
    localparam int CTRL_VLD_BIT  = 1;
    localparam int CTRL_KIND_LSB = 4;
    localparam int CTRL_ROLE_BIT = 7;

    // True for target-side receive classes that must be reported.
    function automatic logic kind_reportable(input logic [2:0] k);
        return (k == KIND_WR_REQ) || (k == KIND_RD_CPL) ||
               (k == KIND_CFG_WR) || (k == KIND_SPL_CMSG);
    endfunction

endpackage

// File: rtl/ecc_err_classify.sv
// Decides whether a correctable error strobe must be logged.
// Purely combinational; assumes inputs are stable around the clock edge.
module ecc_err_classify
    import ecc_log_pkg::*;
(
    input  logic       err_strobe,
    input  logic [2:0] txn_kind,
    input  logic       is_target,
    input  logic       mode_enh,
    input  logic       corr_en,
    output logic       log_evt
);

    // Gate on operating mode, role and reportable class.
    always_comb begin
        log_evt = err_strobe && mode_enh && corr_en && is_target &&
                  kind_reportable(txn_kind);
    end

endmodule

// File: rtl/ecc_err_log_regs.sv
// Holds the record of the most recent logged error and its valid flag.
// Assumes one log event per cycle at most; a new event overwrites the record.
module ecc_err_log_regs #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_evt,
    input  logic              clr_valid,
    input  logic [2:0]        kind_in,
    input  logic              role_in,
    input  logic [ADDR_W-1:0] lo_in,
    input  logic [ADDR_W-1:0] hi_in,
    input  logic [ATTR_W-1:0] attr_in,
    output logic              valid,
    output logic [2:0]        kind_q,
    output logic              role_q,
    output logic [ADDR_W-1:0] lo_q,
    output logic [ADDR_W-1:0] hi_q,
    output logic [ATTR_W-1:0] attr_q
);

    // Capture transaction details on each logged error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            role_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
            attr_q <= '0;
        end else if (log_evt) begin
            kind_q <= kind_in;
            role_q <= role_in;
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            attr_q <= attr_in;
        end
    end

    // Valid flag: set by a log event, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         valid <= 1'b0;
        else if (log_evt)   valid <= 1'b1;
        else if (clr_valid) valid <= 1'b0;
    end

endmodule

// File: rtl/ecc_err_status.sv
// Sticky detected-error status bit with mask gating and write-1-to-clear.
// Assumes set wins over a clear arriving in the same cycle.
module ecc_err_status (
    input  logic clk,
    input  logic rst_n,
    input  logic log_evt,
    input  logic mask,
    input  logic clr,
    output logic sts
);

    logic set_req;

    // Setting is allowed only while the mask is clear.
    always_comb set_req = log_evt && !mask;

    // Sticky status register.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts <= 1'b0;
        else if (set_req) sts <= 1'b1;
        else if (clr)     sts <= 1'b0;
    end

endmodule

// File: rtl/ecc_err_logger.sv
// Top of the correctable ECC error logger: classification, log record,
// sticky status and a register read / write-1-to-clear port.
// Assumes DATA_W covers ADDR_W, ATTR_W and the 8 control bits.
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_strobe,
    input  logic [2:0]        txn_kind,
    input  logic              is_target,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [ATTR_W-1:0] attr,
    input  logic              mode_enh,
    input  logic              corr_en,
    input  logic              irq_mask,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              err_status,
    output logic              irq
);

    localparam int CTRL_USED = CTRL_ROLE_BIT + 1;

    logic              log_evt;
    logic              ctrl_wr;
    logic              clr_sts;
    logic              clr_vld;
    logic              valid;
    logic [2:0]        kind_q;
    logic              role_q;
    logic [ADDR_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_q;
    logic [ATTR_W-1:0] attr_q;
    logic              sts;
    logic [DATA_W-1:0] ctrl_word;

    ecc_err_classify u_classify (
        .err_strobe (err_strobe),
        .txn_kind   (txn_kind),
        .is_target  (is_target),
        .mode_enh   (mode_enh),
        .corr_en    (corr_en),
        .log_evt    (log_evt)
    );

    // Decode write-1-to-clear requests on the control register.
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == REG_CTRL);
        clr_sts = ctrl_wr && reg_wdata[CTRL_STS_BIT];
        clr_vld = ctrl_wr && reg_wdata[CTRL_VLD_BIT];
    end

    ecc_err_log_regs #(
        .ADDR_W (ADDR_W),
        .ATTR_W (ATTR_W)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_evt   (log_evt),
        .clr_valid (clr_vld),
        .kind_in   (txn_kind),
        .role_in   (is_target),
        .lo_in     (addr_lo),
        .hi_in     (addr_hi),
        .attr_in   (attr),
        .valid     (valid),
        .kind_q    (kind_q),
        .role_q    (role_q),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .attr_q    (attr_q)
    );

    ecc_err_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .log_evt (log_evt),
        .mask    (irq_mask),
        .clr     (clr_sts),
        .sts     (sts)
    );

    // Assemble the control/status word.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_STS_BIT] = sts;
        ctrl_word[CTRL_VLD_BIT] = valid;
        ctrl_word[CTRL_KIND_LSB +: 3] = kind_q;
        ctrl_word[CTRL_ROLE_BIT] = role_q;
    end

    // Select the register shown on the read port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: reg_rdata = ctrl_word;
            REG_ADR1: reg_rdata[ADDR_W-1:0] = lo_q;
            REG_ADR2: reg_rdata[ADDR_W-1:0] = hi_q;
            default:  reg_rdata[ATTR_W-1:0] = attr_q;
        endcase
    end

    // Status and interrupt follow the sticky bit.
    always_comb begin
        err_status = sts;
        irq        = sts;
    end

    if (DATA_W < ADDR_W || DATA_W < ATTR_W || DATA_W < CTRL_USED) begin : g_bad_width
        initial $error("DATA_W too small for logged fields");
    end

endmodule

// File: rtl/ecc_err_logger_chk.sv
// Port-level properties of the correctable error logger, bound to the top.
// Assumes a synchronous active-low reset.
module ecc_err_logger_chk #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_strobe,
    input logic [2:0]        txn_kind,
    input logic              is_target,
    input logic [ADDR_W-1:0] addr_lo,
    input logic [ADDR_W-1:0] addr_hi,
    input logic              mode_enh,
    input logic              corr_en,
    input logic              irq_mask,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              err_status,
    input logic              irq
);

    logic reportable;
    logic clr_req;

    always_comb begin
        reportable = err_strobe && mode_enh && corr_en && is_target &&
                     (txn_kind == 3'd1 || txn_kind == 3'd2 ||
                      txn_kind == 3'd3 || txn_kind == 3'd5);
        clr_req = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];
    end

    // R1: with handling disabled, a strobe leaves status alone
    p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !(mode_enh && corr_en) && !clr_req) |=> $stable(err_status));

    // R2: initiator errors leave status alone
    p_initiator_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !is_target && !clr_req) |=> $stable(err_status));

    // R6: an unmasked reportable error raises status
    p_set_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reportable && !irq_mask) |=> err_status);

    // R6: a masked reportable error leaves status alone
    p_masked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reportable && irq_mask && !clr_req) |=> $stable(err_status));

    // R9: set wins over a simultaneous clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reportable && !irq_mask && clr_req) |=> err_status);

    // R8: a clear with no set drops status
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !reportable) |=> !err_status);

    // R7: interrupt line tracks the status bit
    p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == err_status);

endmodule

bind ecc_err_logger ecc_err_logger_chk #(
    .ADDR_W (ADDR_W),
    .ATTR_W (ATTR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_strobe (err_strobe),
    .txn_kind   (txn_kind),
    .is_target  (is_target),
    .addr_lo    (addr_lo),
    .addr_hi    (addr_hi),
    .mode_enh   (mode_enh),
    .corr_en    (corr_en),
    .irq_mask   (irq_mask),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .err_status (err_status),
    .irq        (irq)
);

// File: tb/test_ecc_err_logger.sv
// Scoreboard bench: the driver applies one cycle of stimulus at the falling
// edge and queues the expected port values; the monitor compares them just
// after the rising edge that consumes that stimulus.
module test_ecc_err_logger;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int ATTR_W = 16;
    localparam int DATA_W = 32;

    typedef struct {
        logic [DATA_W-1:0] rdata;
        logic              sts;
        logic              irq;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_strobe = 1'b0;
    logic [2:0]        txn_kind = '0;
    logic              is_target = 1'b0;
    logic [ADDR_W-1:0] addr_lo = '0;
    logic [ADDR_W-1:0] addr_hi = '0;
    logic [ATTR_W-1:0] attr = '0;
    logic              mode_enh = 1'b0;
    logic              corr_en = 1'b0;
    logic              irq_mask = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              err_status;
    logic              irq;

    int n_run = 0;
    int n_fail = 0;
    exp_t sb[$];

    // Reference model state
    logic              m_sts, m_vld, m_role;
    logic [2:0]        m_kind;
    logic [ADDR_W-1:0] m_lo, m_hi;
    logic [ATTR_W-1:0] m_attr;

    ecc_err_logger #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)) i_ecc_err_logger (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .txn_kind(txn_kind),
        .is_target(is_target), .addr_lo(addr_lo), .addr_hi(addr_hi), .attr(attr),
        .mode_enh(mode_enh), .corr_en(corr_en), .irq_mask(irq_mask),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_status(err_status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] model_read(input logic [1:0] a);
        logic [DATA_W-1:0] v;
        v = '0;
        case (a)
            2'd0: begin v[0] = m_sts; v[1] = m_vld; v[6:4] = m_kind; v[7] = m_role; end
            2'd1: v[ADDR_W-1:0] = m_lo;
            2'd2: v[ADDR_W-1:0] = m_hi;
            default: v[ATTR_W-1:0] = m_attr;
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, updates the model, queues the expectation.
    task automatic step(input string req, input logic strobe, input logic [2:0] kind,
                        input logic tgt, input logic [ADDR_W-1:0] lo,
                        input logic [ADDR_W-1:0] hi, input logic [ATTR_W-1:0] at,
                        input logic me, input logic ce, input logic mk,
                        input logic wr, input logic [1:0] ra, input logic [DATA_W-1:0] wd);
        exp_t e;
        logic rep, do_log;
        @(negedge clk);
        err_strobe = strobe; txn_kind = kind; is_target = tgt;
        addr_lo = lo; addr_hi = hi; attr = at;
        mode_enh = me; corr_en = ce; irq_mask = mk;
        reg_wr = wr; reg_addr = ra; reg_wdata = wd;
        rep = (kind == 3'd1) || (kind == 3'd2) || (kind == 3'd3) || (kind == 3'd5);
        do_log = strobe && me && ce && tgt && rep;
        if (do_log) begin
            m_lo = lo; m_hi = hi; m_attr = at; m_kind = kind; m_role = tgt; m_vld = 1'b1;
            if (!mk) m_sts = 1'b1;
            else if (wr && ra == 2'd0 && wd[0]) m_sts = 1'b0;
        end else if (wr && ra == 2'd0) begin
            if (wd[0]) m_sts = 1'b0;
            if (wd[1]) m_vld = 1'b0;
        end
        e.rdata = model_read(ra);
        e.sts = m_sts;
        e.irq = m_sts;
        e.req = req;
        sb.push_back(e);
    endtask

    // Idle cycle that only reads a register.
    task automatic rd(input string req, input logic [1:0] ra);
        step(req, 1'b0, 3'd0, 1'b0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0, ra, '0);
    endtask

    // Monitor: compare right after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, reg_rdata, e.rdata);
            check({e.req, " status"}, {31'd0, err_status}, {31'd0, e.sts});
            check("R7 irq", {31'd0, irq}, {31'd0, e.irq});
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        m_sts = 0; m_vld = 0; m_role = 0; m_kind = 0; m_lo = 0; m_hi = 0; m_attr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10 reset state of every register
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); reg_addr = a[1:0]; #1;
            check("R10 reset", reg_rdata, '0);
        end
        check("R7 reset status", {31'd0, err_status}, 32'd0);

        // R1: mode or correction disabled
        step("R1 mode off", 1, 3'd1, 1, 32'h1111_0000, 32'h1, 16'h11, 0, 1, 0, 0, 2'd1, '0);
        step("R1 corr off", 1, 3'd1, 1, 32'h2222_0000, 32'h2, 16'h22, 1, 0, 0, 0, 2'd0, '0);
        // R2: initiator, every kind
        for (int k = 0; k < 8; k++)
            step("R2 initiator", 1, k[2:0], 0, 32'h3300_0000 + k, 32'h33, 16'h33, 1, 1, 0, 0, 2'd1, '0);
        rd("R2 initiator ctrl", 2'd0);
        // R3: target non-reportable kinds
        step("R3 rd req", 1, 3'd0, 1, 32'h4444_0000, 32'h44, 16'h44, 1, 1, 0, 0, 2'd1, '0);
        step("R3 cfg cmsg", 1, 3'd4, 1, 32'h4545_0000, 32'h45, 16'h45, 1, 1, 0, 0, 2'd0, '0);
        step("R3 code 6", 1, 3'd6, 1, 32'h4646_0000, 32'h46, 16'h46, 1, 1, 0, 0, 2'd3, '0);
        step("R3 code 7", 1, 3'd7, 1, 32'h4747_0000, 32'h47, 16'h47, 1, 1, 0, 0, 2'd2, '0);
        // R4: reportable kind logs, read every register
        step("R4 write log", 1, 3'd1, 1, 32'hA5A5_0001, 32'h0000_00B1, 16'hC001, 1, 1, 0, 0, 2'd1, '0);
        rd("R4 addr2", 2'd2);
        rd("R4 attr", 2'd3);
        rd("R4 ctrl", 2'd0);
        // R8: write to other register ignored, clear status only, then valid
        step("R8 other reg", 0, 3'd0, 0, '0, '0, '0, 1, 1, 0, 1, 2'd1, 32'hFFFF_FFFF);
        rd("R8 other reg ctrl", 2'd0);
        step("R8 zero write", 0, 3'd0, 0, '0, '0, '0, 1, 1, 0, 1, 2'd0, 32'h0);
        step("R8 clr sts", 0, 3'd0, 0, '0, '0, '0, 1, 1, 0, 1, 2'd0, 32'h1);
        step("R8 clr vld", 0, 3'd0, 0, '0, '0, '0, 1, 1, 0, 1, 2'd0, 32'h2);
        // R5: overwrite through each other reportable kind
        step("R5 rd cpl", 1, 3'd2, 1, 32'hB000_0002, 32'hB2, 16'h0B02, 1, 1, 0, 0, 2'd0, '0);
        step("R5 cfg wr", 1, 3'd3, 1, 32'hB000_0003, 32'hB3, 16'h0B03, 1, 1, 0, 0, 2'd1, '0);
        step("R5 split", 1, 3'd5, 1, 32'hB000_0005, 32'hB5, 16'h0B05, 1, 1, 0, 0, 2'd0, '0);
        rd("R5 addr2", 2'd2);
        rd("R5 attr", 2'd3);
        // R6: masked error after clearing status
        step("R6 clr", 0, 3'd0, 0, '0, '0, '0, 1, 1, 0, 1, 2'd0, 32'h3);
        step("R6 masked", 1, 3'd1, 1, 32'hC0C0_0006, 32'hC6, 16'h0C06, 1, 1, 1, 0, 2'd0, '0);
        rd("R6 masked addr", 2'd1);
        step("R6 unmasked", 1, 3'd3, 1, 32'hC0C0_0007, 32'hC7, 16'h0C07, 1, 1, 0, 0, 2'd0, '0);
        // R9: set and clear together
        step("R9 set vs clr", 1, 3'd2, 1, 32'hD0D0_0009, 32'hD9, 16'h0D09, 1, 1, 0, 1, 2'd0, 32'h3);
        step("R9 masked clr", 1, 3'd1, 1, 32'hD0D0_000A, 32'hDA, 16'h0D0A, 1, 1, 1, 1, 2'd0, 32'h3);
        rd("R9 final", 2'd0);

        repeat (3) @(posedge clk);
        #3;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule